// File: doc/BRIEF.md
# Stable Matching Proposal Engine

This engine pairs N proposers with N acceptors so that no proposer and acceptor would both rather be matched to each other than to the partners they end up with. In a combined input-output queued switch, the outputs act as proposers and the inputs act as acceptors. Both sides' preference lists are loaded through a single write port before a run.

A start pulse begins the run. The engine uses deferred acceptance. Each clock, the free proposer with the lowest index offers itself to the most preferred acceptor it has not yet tried. If that acceptor is unmatched, it accepts. If the acceptor holds a partner it likes less than the newcomer, it drops that partner, and the dropped proposer becomes free again. In every other case the offer is turned down.

Acceptor lists are stored inverted, as a rank for each proposer. Comparing two proposers is therefore a single compare. When no proposer is left free, the engine raises `done` and presents each proposer's partner on a flat output vector.

Top module: `stable_match_engine`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: A write with `wr_side`=0 stores acceptor `wr_val` at list position `wr_pos` of proposer `wr_agent`, where position 0 is the most preferred. A write with `wr_side`=1 states that proposer `wr_val` sits at position `wr_pos` of acceptor `wr_agent`'s list, where position 0 is the most preferred.
- R3: A `start` pulse discards every engagement and list pointer from earlier runs. On the next cycle `busy` is high and `done` is low, and a repeated run over the same tables gives the same pairs.
- R4: Each cycle with `busy` high makes exactly one proposal. The proposer is the lowest-indexed free proposer, and the target is the next acceptor on its list that it has not yet tried. The number of cycles from the start edge to the rise of `done` therefore equals the number of proposals that this ordering makes.
- R5: An unmatched acceptor always accepts the offer it receives, and a matched acceptor never becomes unmatched during a run.
- R6: A matched acceptor that ranks the newcomer strictly above its current partner takes the newcomer and frees the old partner.
- R7: Otherwise the proposer stays free and advances to its next choice.
- R8: `done` rises on the edge whose proposal leaves no proposer free. On that same edge `busy` falls. `done` then stays high until the next `start`, and `busy` and `done` are never high together.
- R9: When `done` is high, the field `partner_flat[p*IW +: IW]` gives proposer p's acceptor. The pairs form a one-to-one matching with no blocking pair. Using 0-based indices, the 4x4 case with proposer lists 0:[1,3,2,0], 1:[0,3,2,1], 2:[3,2,1,0], 3:[0,1,3,2] and acceptor lists 0:[0,3,2,1], 1:[2,0,3,1], 2:[0,1,2,3], 3:[1,0,3,2] yields 0->1, 1->3, 2->2, 3->0.
- R10: Writes presented while `busy` is high are ignored, so the tables are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new matching run |
| wr_en | input | 1 | Table write strobe |
| wr_side | input | 1 | 0 = proposer list, 1 = acceptor list |
| wr_agent | input | IW | Proposer or acceptor being written |
| wr_pos | input | IW | List position, 0 = most preferred |
| wr_val | input | IW | Index of the agent at that position |
| busy | output | 1 | Proposal rounds in progress |
| done | output | 1 | Matching complete and stable |
| partner_flat | output | N*IW | Acceptor of each proposer, IW bits per proposer |

## Verification
The engine is run on several kinds of tables, and each kind tests something different:
- The fixed 4x4 case pins down the exact pairs.
- Identical lists on both sides force every later proposer through all earlier rejections. This measures the rejection path and the cycle count.
- Acceptor lists reversed against the proposer lists force a release on almost every proposal, which exercises the swap path.
- A sweep of generated random permutations is compared against an arithmetic model, pair by pair and cycle by cycle, and each result is also checked for blocking pairs.
- A write issued during a run, followed by a repeat run, shows whether the tables and the restart behaviour are intact.

// File: rtl/stable_match_engine.sv
module stable_match_engine #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wr_en,
  input  logic            wr_side,
  input  logic [IW-1:0]   wr_agent,
  input  logic [IW-1:0]   wr_pos,
  input  logic [IW-1:0]   wr_val,
  output logic            busy,
  output logic            done,
  output logic [N*IW-1:0] partner_flat
);

  logic [IW-1:0] plist [N][N];
  logic [IW-1:0] arank [N][N];
  logic [IW-1:0] ptr   [N];
  logic [IW-1:0] owner [N];
  logic [IW-1:0] mate  [N];
  logic [N-1:0]  free;
  logic [N-1:0]  taken;

  logic [IW-1:0] sel, tgt, own;
  logic          win;
  logic [N-1:0]  free_nx;

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (free[i]) sel = IW'(i);
  end

  assign tgt = plist[sel][ptr[sel]];
  assign own = owner[tgt];
  assign win = !taken[tgt] || (arank[tgt][sel] < arank[tgt][own]);

  always_comb begin
    free_nx = free;
    if (win) begin
      free_nx[sel] = 1'b0;
      if (taken[tgt]) free_nx[own] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !busy) begin
      if (!wr_side) plist[wr_agent][wr_pos] <= wr_val;
      else          arank[wr_agent][wr_val] <= wr_pos;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      free  <= '0;
      taken <= '0;
      for (int i = 0; i < N; i++) begin
        ptr[i]   <= '0;
        owner[i] <= '0;
        mate[i]  <= '0;
      end
    end else if (start) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      free  <= '1;
      taken <= '0;
      for (int i = 0; i < N; i++) ptr[i] <= '0;
    end else if (busy) begin
      ptr[sel] <= ptr[sel] + 1'b1;
      if (win) begin
        taken[tgt] <= 1'b1;
        owner[tgt] <= sel;
        mate[sel]  <= tgt;
      end
      free <= free_nx;
      if (free_nx == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign partner_flat[g*IW +: IW] = mate[g];
  end

endmodule

// File: rtl/stable_match_checker.sv
module stable_match_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] free,
  input logic [N-1:0] taken
);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done));

  p_free_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> ($countones(free) <= $past($countones(free))));

  p_taken_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> ((taken & $past(taken)) == $past(taken)));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_all_matched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (free == '0 && $countones(taken) == N));

endmodule

bind stable_match_engine stable_match_checker #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .free(free), .taken(taken)
);

// File: tb/stable_match_engine_tb.sv
`timescale 1ns/1ps
module stable_match_engine_tb_top;
  localparam int N  = 4;
  localparam int IW = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic wr_en = 1'b0, wr_side = 1'b0;
  logic [IW-1:0] wr_agent = '0, wr_pos = '0, wr_val = '0;
  logic busy, done;
  logic [N*IW-1:0] partner_flat;

  always #4 clk = ~clk;

  stable_match_engine #(.N(N), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_side(wr_side),
    .wr_agent(wr_agent), .wr_pos(wr_pos), .wr_val(wr_val),
    .busy(busy), .done(done), .partner_flat(partner_flat));

  int pp [N][N];
  int al [N][N];
  int ar [N][N];
  int ref_mate [N];
  int ref_cnt;
  int checks = 0, fails = 0;
  bit finished = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load();
    for (int a = 0; a < N; a++)
      for (int k = 0; k < N; k++) ar[a][al[a][k]] = k;
    for (int s = 0; s < 2; s++)
      for (int x = 0; x < N; x++)
        for (int k = 0; k < N; k++) begin
          @(negedge clk);
          wr_en = 1; wr_side = s[0]; wr_agent = x[IW-1:0]; wr_pos = k[IW-1:0];
          wr_val = (s == 0) ? pp[x][k][IW-1:0] : al[x][k][IW-1:0];
        end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic model();
    int ptr [N];
    int own [N];
    bit fr [N];
    bit tk [N];
    int p, a;
    for (int i = 0; i < N; i++) begin ptr[i] = 0; fr[i] = 1; tk[i] = 0; own[i] = 0; ref_mate[i] = 0; end
    ref_cnt = 0;
    forever begin
      p = -1;
      for (int i = N - 1; i >= 0; i--) if (fr[i]) p = i;
      if (p < 0) break;
      a = pp[p][ptr[p]];
      ptr[p]++;
      ref_cnt++;
      if (!tk[a]) begin
        tk[a] = 1; own[a] = p; ref_mate[p] = a; fr[p] = 0;
      end else if (ar[a][p] < ar[a][own[a]]) begin
        fr[own[a]] = 1; own[a] = p; ref_mate[p] = a; fr[p] = 0;
      end
    end
  endtask

  task automatic run(input bit corrupt);
    int cyc;
    int m [N];
    int seen;
    int pos_m, pos_a, owner_a;
    bit stable;
    model();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy && !done, "R3 busy after start", {busy, done}, 2);
    if (corrupt) begin
      wr_en = 1; wr_side = 1; wr_agent = 0; wr_pos = 0; wr_val = 3;
    end
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk); cyc++;
      if (corrupt && cyc == 1) begin
        wr_side = 0; wr_agent = 0; wr_pos = 0; wr_val = 2'(pp[0][0] + 1);
      end
      if (corrupt && cyc == 2) wr_en = 0;
    end
    wr_en = 0;
    chk(cyc == ref_cnt, "R4 proposal cycles", cyc, ref_cnt);
    chk(!busy && done, "R8 done/busy", {busy, done}, 1);
    seen = 0;
    for (int p = 0; p < N; p++) begin
      m[p] = int'(partner_flat[p*IW +: IW]);
      chk(m[p] == ref_mate[p], "R9 partner", m[p], ref_mate[p]);
      seen |= (1 << m[p]);
    end
    chk(seen == (1 << N) - 1, "R9 one-to-one", seen, (1 << N) - 1);
    stable = 1;
    for (int p = 0; p < N; p++)
      for (int a = 0; a < N; a++) begin
        pos_m = 0; pos_a = 0; owner_a = 0;
        for (int k = 0; k < N; k++) begin
          if (pp[p][k] == m[p]) pos_m = k;
          if (pp[p][k] == a) pos_a = k;
        end
        for (int q = 0; q < N; q++) if (m[q] == a) owner_a = q;
        if (pos_a < pos_m && ar[a][p] < ar[a][owner_a]) stable = 0;
      end
    chk(stable, "R6 R7 no blocking pair", 0, 1);
    repeat (3) @(negedge clk);
    chk(done && !busy, "R8 done held", {busy, done}, 1);
  endtask

  function automatic int rnd(input int lim);
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 16) % lim);
  endfunction

  task automatic perm_row(inout int row [N]);
    int j, t;
    for (int i = 0; i < N; i++) row[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      j = rnd(i + 1); t = row[i]; row[i] = row[j]; row[j] = t;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int row [N];
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 reset state", {busy, done}, 0);
    rst_n = 1;
    @(negedge clk);

    // R9 / R2: fixed 4x4 case
    pp[0] = '{1,3,2,0}; pp[1] = '{0,3,2,1}; pp[2] = '{3,2,1,0}; pp[3] = '{0,1,3,2};
    al[0] = '{0,3,2,1}; al[1] = '{2,0,3,1}; al[2] = '{0,1,2,3}; al[3] = '{1,0,3,2};
    load();
    run(0);
    chk(partner_flat == {2'd0, 2'd2, 2'd3, 2'd1}, "R9 fixed case", int'(partner_flat), 8'b00101101);
    // R10: writes during run ignored; R3 rerun gives same result
    run(1);
    run(0);

    // R7: identical lists on both sides
    for (int x = 0; x < N; x++) for (int k = 0; k < N; k++) begin pp[x][k] = k; al[x][k] = k; end
    load();
    run(0);
    chk(ref_cnt == N * (N + 1) / 2, "R7 rejection count", ref_cnt, N * (N + 1) / 2);

    // R6: acceptors prefer later proposers
    for (int x = 0; x < N; x++) for (int k = 0; k < N; k++) begin pp[x][k] = k; al[x][k] = N - 1 - k; end
    load();
    run(0);

    // R4 R5: random permutation sweep
    for (int t = 0; t < 40; t++) begin
      for (int x = 0; x < N; x++) begin
        perm_row(row); pp[x] = row;
        perm_row(row); al[x] = row;
      end
      load();
      run(0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule